// File: doc/BRIEF.md
# Inbound Doorbell Receive Queue

This block takes incoming doorbell packets (a source ID, a target ID and a 16-bit info value) and appends each one as an 8-byte entry to a circular ring in system memory. The entry is written through a plain memory write port, and an enqueue pointer then moves to the next slot. Software reads entries from the address held in the dequeue pointer. It frees an entry by writing a one-shot increment bit in the mode register. While the ring holds entries, a sticky "doorbell waiting" flag is kept set. An interrupt output combines that flag with a queue-full flag and a receive-error flag, each behind its own enable bit.

The ring is aligned to its own size. Only the low offset bits of a pointer wrap, and the upper address bits stay fixed. The ring size comes from a 4-bit entry-count field that holds log2(entries) - 2. The hardware maximum is a parameter: the default of 512 entries spans one 4 KB page, so the head entry's offset is the low 12 bits of the dequeue pointer. One slot is always left unused, so a ring of N entries holds N-1 doorbells. Each doorbell gets a one-cycle response code one clock after it arrives: accepted, retry or error.

Register map (`reg_addr`): 0 = mode, 1 = status, 2 = dequeue pointer, 3 = enqueue pointer. Reads are combinational. A write to the mode register replaces every mode field at once.

Top module: `doorbell_rx_queue`

## Requirements
- R1: After reset both pointers read 0, status reads 0, `irq`, `mem_we` and `rsp_valid` are 0, and mode reads only the entry-count field (bits 15:12), set to LOG2_ENTRIES-2.
- R2: An accepted doorbell drives `mem_we` in the cycle it is presented, with `mem_addr` equal to the enqueue pointer. `mem_wdata` holds halfword 0 = 0 in [63:48], target ID in [47:32], source ID in [31:16] and info in [15:0].
- R3: Each accepted doorbell moves the enqueue pointer on by 8 bytes. The pointer wraps inside a ring of 2^(field+2) entries and keeps the bits above the ring span. A field value written above LOG2_ENTRIES-2 is stored as LOG2_ENTRIES-2.
- R4: Writing mode with bit 1 set advances the dequeue pointer by one entry, with the same wrap. Bit 1 always reads 0. The write is ignored when the pointers are equal.
- R5: Status bit 0 (doorbell waiting) is set on the clock edge after any cycle in which the two pointers differ.
- R6: Status bits 0, 4 and 7 are cleared by writing one. A new setting event in the same cycle wins, so bit 0 comes back at once while entries remain.
- R7: A ring of N entries holds N-1 doorbells. A doorbell arriving when the next enqueue slot equals the dequeue pointer is not written, sets status bit 4 (queue full) and gets a retry response.
- R8: `irq` = (bit 0 AND mode bit 5) OR (bit 4 AND mode bit 4) OR (bit 7 AND mode bit 6).
- R9: With mode bit 0 (enable) clear, a doorbell is not written, moves no pointer, sets no flag and gets a retry response.
- R10: An enabled doorbell flagged bad on `db_bad` is not written. It sets status bit 7 (receive error) and gets an error response.
- R11: `mem_snoop` follows mode bit 20.
- R12: `rsp_valid` is high exactly one cycle after each cycle with `db_valid`. `rsp_code` is 0 for accept, 1 for retry and 2 for error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| db_valid | input | 1 | Doorbell packet present this cycle |
| db_bad | input | 1 | Packet arrived with a receive error |
| db_src | input | 16 | Source ID |
| db_tgt | input | 16 | Target ID |
| db_info | input | 16 | Info field |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | Response: 0 accept, 1 retry, 2 error |
| mem_we | output | 1 | Ring entry write strobe |
| mem_addr | output | ADDR_W | Byte address of the entry |
| mem_wdata | output | 64 | Packed entry |
| mem_snoop | output | 1 | Coherent-write attribute |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with LOG2_ENTRIES = 4, which gives a 16-entry maximum ring and an entry-count reset value of 2. This makes the clamp of an oversized field easy to observe. The bench then programs the field to 0, a 4-entry ring. With that size, filling the ring, the retry on the fourth doorbell, the queue-full flag and the wrap of both pointers inside the 32-byte span above a nonzero base can all be reached in a few dozen cycles.

// File: rtl/dbq_pkg.sv
// Package: shared encodings of the doorbell receive queue.
// Assumes: registers are 32 bits wide and ring entries are 8 bytes.
package dbq_pkg;
    localparam logic [1:0] REG_MODE = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DEQ  = 2'd2;
    localparam logic [1:0] REG_ENQ  = 2'd3;

    localparam int MB_EN      = 0;
    localparam int MB_DEQ_INC = 1;
    localparam int MB_IE_FULL = 4;
    localparam int MB_IE_WAIT = 5;
    localparam int MB_IE_ERR  = 6;
    localparam int MB_SIZE_LO = 12;
    localparam int MB_SNOOP   = 20;

    localparam int SB_WAIT = 0;
    localparam int SB_FULL = 4;
    localparam int SB_ERR  = 7;

    localparam int ENTRY_SHIFT = 3;

    typedef enum logic [1:0] {
        RSP_ACCEPT = 2'd0,
        RSP_RETRY  = 2'd1,
        RSP_ERROR  = 2'd2
    } rsp_e;

    // Pack one ring entry: pad, target, source, info from high to low halfword.
    function automatic logic [63:0] pack_entry(input logic [15:0] tgt,
                                               input logic [15:0] src,
                                               input logic [15:0] info);
        return {16'h0000, tgt, src, info};
    endfunction
endpackage

// File: rtl/dbq_ring_ptr.sv
// Module: one ring pointer (enqueue or dequeue).
// Holds an 8-byte aligned byte address. Stepping wraps the bits under
// span_mask and keeps the bits above it. A load takes priority over a step.
// Assumes span_mask is a contiguous low mask of at least 5 bits.
module dbq_ring_ptr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic [ADDR_W-1:0] span_mask,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [ADDR_W-1:0] ptr_next
);
    import dbq_pkg::*;

    // Purpose: address of the following entry, wrapped inside the ring span.
    always_comb begin
        ptr_next = (ptr_q & ~span_mask) |
                   ((ptr_q + ADDR_W'(1 << ENTRY_SHIFT)) & span_mask);
    end

    // Purpose: hold the pointer; software load first, then hardware step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= {load_val[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
        end else if (step) begin
            ptr_q <= ptr_next;
        end
    end
endmodule

// File: rtl/dbq_ctrl.sv
// Module: mode and status registers with the interrupt combine.
// Mode fields are replaced as a whole on a mode write. The dequeue-increment
// bit is never stored; it is decoded into a one-cycle strobe. Status flags are
// sticky, cleared by writing one, and a set event wins over a clear.
// Assumes LOG2_ENTRIES is between 2 and 17.
module dbq_ctrl #(
    parameter int LOG2_ENTRIES = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        nonempty,
    input  logic        set_full,
    input  logic        set_err,
    output logic        unit_en,
    output logic        snoop,
    output logic [3:0]  size_field,
    output logic        deq_step,
    output logic [2:0]  stat_q,
    output logic [31:0] mode_rd,
    output logic [31:0] stat_rd,
    output logic        irq
);
    import dbq_pkg::*;

    localparam logic [3:0] SIZE_MAX = 4'(LOG2_ENTRIES - 2);

    logic       ie_full, ie_wait, ie_err;
    logic       mode_we, stat_we;
    logic [3:0] wr_size;
    logic [2:0] clr;
    logic       unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:21], reg_wdata[19:16], reg_wdata[11:8],
                            reg_wdata[3:2]};

    // Purpose: decode register writes and clamp the entry-count field.
    always_comb begin
        mode_we  = reg_wr && (reg_addr == REG_MODE);
        stat_we  = reg_wr && (reg_addr == REG_STAT);
        wr_size  = (reg_wdata[MB_SIZE_LO +: 4] > SIZE_MAX) ? SIZE_MAX
                                                          : reg_wdata[MB_SIZE_LO +: 4];
        deq_step = mode_we && reg_wdata[MB_DEQ_INC] && nonempty;
        clr      = stat_we ? {reg_wdata[SB_ERR], reg_wdata[SB_FULL], reg_wdata[SB_WAIT]}
                           : 3'b000;
    end

    // Purpose: mode register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_en    <= 1'b0;
            snoop      <= 1'b0;
            ie_full    <= 1'b0;
            ie_wait    <= 1'b0;
            ie_err     <= 1'b0;
            size_field <= SIZE_MAX;
        end else if (mode_we) begin
            unit_en    <= reg_wdata[MB_EN];
            snoop      <= reg_wdata[MB_SNOOP];
            ie_full    <= reg_wdata[MB_IE_FULL];
            ie_wait    <= reg_wdata[MB_IE_WAIT];
            ie_err     <= reg_wdata[MB_IE_ERR];
            size_field <= wr_size;
        end
    end

    // Purpose: sticky status flags {err, full, wait}; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 3'b000;
        end else begin
            stat_q[0] <= nonempty | (stat_q[0] & ~clr[0]);
            stat_q[1] <= set_full | (stat_q[1] & ~clr[1]);
            stat_q[2] <= set_err  | (stat_q[2] & ~clr[2]);
        end
    end

    // Purpose: register read images and the gated interrupt.
    always_comb begin
        mode_rd                   = '0;
        mode_rd[MB_EN]            = unit_en;
        mode_rd[MB_IE_FULL]       = ie_full;
        mode_rd[MB_IE_WAIT]       = ie_wait;
        mode_rd[MB_IE_ERR]        = ie_err;
        mode_rd[MB_SIZE_LO +: 4]  = size_field;
        mode_rd[MB_SNOOP]         = snoop;
        stat_rd                   = '0;
        stat_rd[SB_WAIT]          = stat_q[0];
        stat_rd[SB_FULL]          = stat_q[1];
        stat_rd[SB_ERR]           = stat_q[2];
        irq = (stat_q[0] & ie_wait) | (stat_q[1] & ie_full) | (stat_q[2] & ie_err);
    end
endmodule

// File: rtl/doorbell_rx_queue.sv
// Module: inbound doorbell receive queue (top).
// Writes each accepted doorbell into a size-aligned memory ring at the
// enqueue pointer and returns a response code one cycle later. One ring slot
// stays empty so that full and empty can be told apart.
// Assumes: ADDR_W <= 32, and memory accepts a write in the cycle mem_we is high.
module doorbell_rx_queue #(
    parameter int ADDR_W       = 32,
    parameter int LOG2_ENTRIES = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              db_valid,
    input  logic              db_bad,
    input  logic [15:0]       db_src,
    input  logic [15:0]       db_tgt,
    input  logic [15:0]       db_info,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    output logic              mem_snoop,
    output logic              irq
);
    import dbq_pkg::*;

    localparam int OFF_W = LOG2_ENTRIES + ENTRY_SHIFT;

    logic              mode_en, deq_step, nonempty, ring_full;
    logic              set_full, set_err, ptr_load;
    logic [3:0]        size_field;
    logic [2:0]        stat_q;
    logic [31:0]       mode_rd, stat_rd;
    logic [ADDR_W-1:0] span_mask, enq_ptr, enq_next, deq_ptr, deq_next;
    logic [ADDR_W-1:0] ptr_wval;
    logic              enq_load, deq_load;
    logic              unused_deq_next;
    rsp_e              rsp_d;

    assign unused_deq_next = ^deq_next;

    dbq_ctrl #(.LOG2_ENTRIES(LOG2_ENTRIES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .nonempty   (nonempty),
        .set_full   (set_full),
        .set_err    (set_err),
        .unit_en    (mode_en),
        .snoop      (mem_snoop),
        .size_field (size_field),
        .deq_step   (deq_step),
        .stat_q     (stat_q),
        .mode_rd    (mode_rd),
        .stat_rd    (stat_rd),
        .irq        (irq)
    );

    // Purpose: ring span mask from the entry-count field, and pointer loads.
    always_comb begin
        span_mask = (ADDR_W'(1) << (32'(size_field) + 32'(ENTRY_SHIFT + 2))) - ADDR_W'(1);
        span_mask = span_mask & ((ADDR_W'(1) << OFF_W) - ADDR_W'(1));
        ptr_wval  = ADDR_W'(reg_wdata);
        enq_load  = reg_wr && (reg_addr == REG_ENQ);
        deq_load  = reg_wr && (reg_addr == REG_DEQ);
        ptr_load  = enq_load || deq_load;
    end

    dbq_ring_ptr #(.ADDR_W(ADDR_W)) u_enq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (enq_load),
        .load_val  (ptr_wval),
        .step      (mem_we),
        .span_mask (span_mask),
        .ptr_q     (enq_ptr),
        .ptr_next  (enq_next)
    );

    dbq_ring_ptr #(.ADDR_W(ADDR_W)) u_deq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (deq_load),
        .load_val  (ptr_wval),
        .step      (deq_step),
        .span_mask (span_mask),
        .ptr_q     (deq_ptr),
        .ptr_next  (deq_next)
    );

    // Purpose: admission decision for the doorbell presented this cycle.
    always_comb begin
        nonempty  = (enq_ptr != deq_ptr);
        ring_full = (enq_next == deq_ptr);
        mem_we    = db_valid && mode_en && !db_bad && !ring_full;
        set_full  = db_valid && mode_en && !db_bad && ring_full;
        set_err   = db_valid && mode_en && db_bad;
        mem_addr  = enq_ptr;
        mem_wdata = pack_entry(db_tgt, db_src, db_info);
        if (!mode_en || ring_full) rsp_d = RSP_RETRY;
        else if (db_bad)           rsp_d = RSP_ERROR;
        else                       rsp_d = RSP_ACCEPT;
        if (mode_en && db_bad)     rsp_d = RSP_ERROR;
    end

    // Purpose: one-cycle-late response to each doorbell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_ACCEPT;
        end else begin
            rsp_valid <= db_valid;
            rsp_code  <= db_valid ? rsp_d : RSP_ACCEPT;
        end
    end

    // Purpose: register read mux.
    always_comb begin
        case (reg_addr)
            REG_MODE: reg_rdata = mode_rd;
            REG_STAT: reg_rdata = stat_rd;
            REG_DEQ:  reg_rdata = 32'(deq_ptr);
            default:  reg_rdata = 32'(enq_ptr);
        endcase
    end
endmodule

// File: rtl/dbq_checker.sv
// Module: temporal checks on the doorbell receive queue, bound to the top.
// Assumes it sees the top's pointers, status flags and enable bit.
module dbq_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_wdata,
    input logic              db_valid,
    input logic              rsp_valid,
    input logic              irq,
    input logic [ADDR_W-1:0] enq_ptr,
    input logic [ADDR_W-1:0] deq_ptr,
    input logic [2:0]        stat,
    input logic              unit_en,
    input logic              ptr_load
);
    // R2: entries land on 8-byte slots with a zero pad halfword
    a_r2_entry_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[2:0] == 3'b000 && mem_wdata[63:48] == 16'h0000));

    // R3: a written entry moves the enqueue pointer
    a_r3_enq_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !ptr_load) |=> (enq_ptr != $past(enq_ptr)));

    // R5: pending entries raise the waiting flag on the next edge
    a_r5_wait_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_ptr != deq_ptr) |=> stat[0]);

    // R8: no flag, no interrupt
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == 3'b000) |-> !irq);

    // R9: a disabled unit writes nothing
    a_r9_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |-> !mem_we);

    // R12: exactly one response per doorbell cycle
    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |=> rsp_valid);
    a_r12_rsp_only_after: assert property (@(posedge clk) disable iff (!rst_n)
        !db_valid |=> !rsp_valid);
endmodule

bind doorbell_rx_queue dbq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .db_valid  (db_valid),
    .rsp_valid (rsp_valid),
    .irq       (irq),
    .enq_ptr   (enq_ptr),
    .deq_ptr   (deq_ptr),
    .stat      (stat_q),
    .unit_en   (mode_en),
    .ptr_load  (ptr_load)
);

// File: tb/doorbell_rx_queue_test.sv
`timescale 1ns/1ps
// Bench: table-driven doorbell fill, then directed tests of dequeue, full
// ring, wrap, disabled unit, receive error and interrupt gating.
module doorbell_rx_queue_test;
    localparam int AW = 32;
    localparam int LG = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          db_valid = 1'b0, db_bad = 1'b0;
    logic [15:0]   db_src = '0, db_tgt = '0, db_info = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_code;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic          mem_snoop, irq;

    int n_chk = 0;
    int n_err = 0;

    logic          s_we, s_rv;
    logic [AW-1:0] s_addr;
    logic [63:0]   s_data;
    logic [1:0]    s_code;
    logic [31:0]   rd;

    // {target, source, info}
    localparam logic [47:0] VEC [4] = '{
        48'h0001_0002_0003, 48'hA5A5_5A5A_FFFF,
        48'hFFFF_0000_8001, 48'h1234_ABCD_0000
    };

    always #4 clk = ~clk;

    doorbell_rx_queue #(.ADDR_W(AW), .LOG2_ENTRIES(LG)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
        .db_bad(db_bad), .db_src(db_src), .db_tgt(db_tgt), .db_info(db_info),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_snoop(mem_snoop),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_db(input logic [15:0] t, input logic [15:0] s,
                           input logic [15:0] i, input logic bad);
        @(negedge clk);
        db_valid = 1'b1; db_bad = bad; db_tgt = t; db_src = s; db_info = i;
        #1 s_we = mem_we; s_addr = mem_addr; s_data = mem_wdata;
        @(negedge clk);
        db_valid = 1'b0; db_bad = 1'b0;
        #1 s_rv = rsp_valid; s_code = rsp_code;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_reg(2'd0, rd); chk("R1 mode", 64'(rd), 64'h2000);
        rd_reg(2'd1, rd); chk("R1 status", 64'(rd), 64'h0);
        rd_reg(2'd2, rd); chk("R1 deq", 64'(rd), 64'h0);
        rd_reg(2'd3, rd); chk("R1 enq", 64'(rd), 64'h0);
        chk("R1 irq/we/rsp", {61'h0, irq, mem_we, rsp_valid}, 64'h0);

        // R9 disabled unit
        send_db(16'h1111, 16'h2222, 16'h3333, 1'b0);
        chk("R9 no write", 64'(s_we), 64'h0);
        chk("R9 R12 retry", {62'h0, s_rv, s_code[0]}, 64'h3);
        rd_reg(2'd3, rd); chk("R9 enq held", 64'(rd), 64'h0);
        rd_reg(2'd1, rd); chk("R9 no flag", 64'(rd), 64'h0);

        // R3 clamp of an oversized entry-count field
        wr_reg(2'd0, 32'h0000_F000);
        rd_reg(2'd0, rd); chk("R3 clamp", 64'(rd), 64'h2000);

        // R11 snoop, then table-driven fill (R2, R3, R12)
        wr_reg(2'd0, 32'h0010_2021);
        chk("R11 snoop", 64'(mem_snoop), 64'h1);
        for (int k = 0; k < 4; k++) begin
            send_db(VEC[k][47:32], VEC[k][31:16], VEC[k][15:0], 1'b0);
            chk("R2 we", 64'(s_we), 64'h1);
            chk("R2 addr", 64'(s_addr), 64'(k * 8));
            chk("R2 data", s_data, {16'h0, VEC[k]});
            chk("R12 accept", {62'h0, s_rv, s_code == 2'd0}, 64'h3);
        end
        rd_reg(2'd3, rd); chk("R3 enq", 64'(rd), 64'h20);

        // R5 waiting flag, R8 irq
        rd_reg(2'd1, rd); chk("R5 waiting", 64'(rd), 64'h1);
        chk("R8 irq wait", 64'(irq), 64'h1);

        // R6 clear while entries remain
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd1, rd); chk("R6 reappears", 64'(rd), 64'h1);

        // R4 dequeue increments
        for (int k = 0; k < 4; k++) begin
            wr_reg(2'd0, 32'h0010_2023);
            rd_reg(2'd2, rd); chk("R4 deq step", 64'(rd), 64'((k + 1) * 8));
        end
        rd_reg(2'd0, rd); chk("R4 bit1 reads 0", 64'(rd), 64'h0010_2021);
        wr_reg(2'd0, 32'h0010_2023);
        rd_reg(2'd2, rd); chk("R4 empty ignored", 64'(rd), 64'h20);
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd1, rd); chk("R6 cleared", 64'(rd), 64'h0);
        chk("R8 irq low", 64'(irq), 64'h0);

        // R7 full ring of 4 entries at base 0x1000
        wr_reg(2'd0, 32'h0000_0001);
        wr_reg(2'd2, 32'h0000_1000);
        wr_reg(2'd3, 32'h0000_1000);
        for (int k = 0; k < 3; k++) begin
            send_db(16'h0100, 16'h0200, 16'(k), 1'b0);
            chk("R7 fill addr", 64'(s_addr), 64'(32'h1000 + k * 8));
        end
        send_db(16'h0100, 16'h0200, 16'h00FF, 1'b0);
        chk("R7 full no write", 64'(s_we), 64'h0);
        chk("R7 R12 retry", {62'h0, s_rv, s_code == 2'd1}, 64'h3);
        rd_reg(2'd1, rd); chk("R7 full flag", 64'(rd), 64'h11);
        chk("R8 gated off", 64'(irq), 64'h0);
        wr_reg(2'd0, 32'h0000_0011);
        chk("R8 full irq", 64'(irq), 64'h1);

        // R3 R4 wrap inside the span
        wr_reg(2'd0, 32'h0000_0013);
        rd_reg(2'd2, rd); chk("R4 deq", 64'(rd), 64'h1008);
        send_db(16'h0100, 16'h0200, 16'h0003, 1'b0);
        chk("R3 last slot", 64'(s_addr), 64'h1018);
        rd_reg(2'd3, rd); chk("R3 enq wrap", 64'(rd), 64'h1000);

        // R10 receive error
        send_db(16'h0100, 16'h0200, 16'h0004, 1'b1);
        chk("R10 no write", 64'(s_we), 64'h0);
        chk("R10 R12 error", {62'h0, s_rv, s_code == 2'd2}, 64'h3);
        rd_reg(2'd1, rd); chk("R10 err flag", 64'(rd), 64'h91);
        rd_reg(2'd3, rd); chk("R10 enq held", 64'(rd), 64'h1000);
        wr_reg(2'd1, 32'h90);
        rd_reg(2'd1, rd); chk("R6 w1c", 64'(rd), 64'h1);
        chk("R8 irq off", 64'(irq), 64'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule